// File: doc/BRIEF.md
# Push-Button Hex Byte Editor

This block lets four push buttons inspect and change a small on-chip memory of sixteen bytes. One pair of buttons moves a 4-bit location pointer forward or backward. The other pair adds or subtracts one from the byte at that location, and the changed byte is stored back.

Three seven-segment digits show the state. One digit shows the pointer. Two digits show the byte being edited, in hexadecimal. The buttons are assumed clean and already synchronous to the clock. Each button is edge-detected inside the block, so holding a button down produces one step only.

The memory has a synchronous write and a registered read address. When the pointer moves, the byte shown is refreshed from memory one cycle later. A synchronous active-low reset clears the pointer, the editing register and all sixteen memory cells.

Top module: `hexmem_editor`

## Requirements
- R1: While `rst_n` is low at a clock edge, the pointer, the editing register and every memory cell become zero. After reset the digits therefore show address 0 and byte 00.
- R2: Key vector 4'b1000 increments the pointer modulo 16. Key vector 4'b0100 decrements it modulo 16. The pointer changes at the first clock edge that sees the press.
- R3: Key vector 4'b0010 adds one to the editing register modulo 256. Key vector 4'b0001 subtracts one modulo 256. The register changes at the first clock edge that sees the press.
- R4: A command is taken only when exactly one key is high and that key was low at the previous clock edge. Any vector with zero, two, three or four keys high changes neither the pointer nor the byte.
- R5: A key held high for any number of cycles produces exactly one step. A further step needs the key to go low for at least one edge and then high again.
- R6: After a byte step, the new byte is written into memory at the current pointer at the next clock edge. It is still there when the pointer leaves the location and later returns.
- R7: After a pointer step, the editing register is loaded with the stored byte of the new location at the following clock edge. For that one cycle, the byte digits still show the previous value.
- R8: A byte step that arrives in the same cycle as a reload is applied to the byte freshly read from memory, not to the stale value.
- R9: Segment outputs are active low, with bit 6 to bit 0 driving segments g,f,e,d,c,b,a. With segments lit written in active-high hex for digits 0..F, the codes are 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71.
- R10: `seg_addr_n` shows the pointer. `seg_hi_n` shows bits 7:4 of the editing register, and `seg_lo_n` shows bits 3:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| key_in | input | 4 | Button levels, active high: [3] pointer up, [2] pointer down, [1] byte up, [0] byte down |
| seg_addr_n | output | 7 | Pointer digit, active low, g..a |
| seg_hi_n | output | 7 | Upper nibble digit of the byte, active low, g..a |
| seg_lo_n | output | 7 | Lower nibble digit of the byte, active low, g..a |

## Verification
The bench first uses single clean presses of each button. Pointer walks past F and back past 0 show the wrap and every glyph. Byte steps below 00 show the byte wrap.

Long holds and chords of two or more keys separate a correct edge-qualified one-hot decoder from a level-sensitive or permissive one. Editing a location, leaving it and returning shows whether the write-back really reached the memory. A pointer press followed at once by a byte press exercises the reload cycle, and shows whether a step is applied to the stale byte or to the fresh one.

A long pseudo-random key stream then checks all three digits every cycle against a behavioural model.

// File: rtl/hexed_pkg.sv
// Package: shared command type, key positions and the hex glyph function.
// Assumes a 4-key panel and 4-bit nibbles for every displayed digit.
package hexed_pkg;

    // Key positions inside the key vector; the decoder depends on them.
    localparam int KEY_VAL_DN  = 0;
    localparam int KEY_VAL_UP  = 1;
    localparam int KEY_PTR_DN  = 2;
    localparam int KEY_PTR_UP  = 3;
    localparam int NUM_KEYS    = 4;
    localparam int SEG_W       = 7;
    localparam int NIB_W       = 4;

    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_PTR_UP = 3'd1,
        CMD_PTR_DN = 3'd2,
        CMD_VAL_UP = 3'd3,
        CMD_VAL_DN = 3'd4
    } edit_cmd_e;

    // Active-high segment pattern, bit 6..0 = g..a.
    function automatic logic [SEG_W-1:0] glyph_on(input logic [NIB_W-1:0] nib);
        logic [SEG_W-1:0] s;
        case (nib)
            4'h0: s = 7'h3F;
            4'h1: s = 7'h06;
            4'h2: s = 7'h5B;
            4'h3: s = 7'h4F;
            4'h4: s = 7'h66;
            4'h5: s = 7'h6D;
            4'h6: s = 7'h7D;
            4'h7: s = 7'h07;
            4'h8: s = 7'h7F;
            4'h9: s = 7'h6F;
            4'hA: s = 7'h77;
            4'hB: s = 7'h7C;
            4'hC: s = 7'h39;
            4'hD: s = 7'h5E;
            4'hE: s = 7'h79;
            default: s = 7'h71;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/hexed_keys.sv
// Key front end: rising-edge detection on every key and decode into one
// command. A command exists only when exactly one key is high and that key
// rose at this edge. Assumes keys are already clean and synchronous.
module hexed_keys
    import hexed_pkg::*;
#(
    parameter int N_KEYS = NUM_KEYS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_KEYS-1:0] key_in,
    output edit_cmd_e         cmd
);

    logic [N_KEYS-1:0] prev_q;
    logic [N_KEYS-1:0] rise;
    logic              single;

    // Remember last key levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= key_in;
    end

    assign rise   = key_in & ~prev_q;
    assign single = (key_in != '0) && ((key_in & (key_in - 1'b1)) == '0);

    // Map a single fresh key to its command.
    always_comb begin
        cmd = CMD_NONE;
        if (single && (rise != '0)) begin
            if      (key_in[KEY_PTR_UP]) cmd = CMD_PTR_UP;
            else if (key_in[KEY_PTR_DN]) cmd = CMD_PTR_DN;
            else if (key_in[KEY_VAL_UP]) cmd = CMD_VAL_UP;
            else if (key_in[KEY_VAL_DN]) cmd = CMD_VAL_DN;
        end
    end

    AST_CMD_SINGLE_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NONE) |-> $onehot(key_in)); // R4

    for (genvar gi = 0; gi < N_KEYS; gi++) begin : g_edge_chk
        AST_EDGE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
            rise[gi] |=> !rise[gi]); // R5
    end

endmodule

// File: rtl/hexed_store.sv
// Byte store: 2**ADDR_W words, synchronous write, registered read address.
// Read data reflects the address presented one edge earlier. Reset clears
// every word.
module hexed_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr_nxt,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];
    logic [ADDR_W-1:0] rd_addr_q;

    // Write port and read-address register; reset clears the array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
            rd_addr_q <= '0;
        end else begin
            if (wr_en) cells[wr_addr] <= wr_data;
            rd_addr_q <= rd_addr_nxt;
        end
    end

    assign rd_data = cells[rd_addr_q];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (rd_addr_nxt == wr_addr)) |=> (rd_data == $past(wr_data))); // R6

endmodule

// File: rtl/hexed_glyph.sv
// One hex digit decoder: nibble in, active-low g..a segment pattern out.
module hexed_glyph
    import hexed_pkg::*;
(
    input  logic [NIB_W-1:0] nib,
    output logic [SEG_W-1:0] seg_n
);

    assign seg_n = ~glyph_on(nib);

endmodule

// File: rtl/hexmem_editor.sv
// Top: byte editor around a 16 x 8 store. Holds the pointer and the editing
// register, writes an edited byte back one edge after each byte step, and
// reloads the editing register one edge after each pointer step.
// Assumes clean synchronous keys, one command per edge at most.
module hexmem_editor
    import hexed_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_KEYS-1:0]   key_in,
    output logic [SEG_W-1:0]      seg_addr_n,
    output logic [SEG_W-1:0]      seg_hi_n,
    output logic [SEG_W-1:0]      seg_lo_n
);

    localparam int N_DIGITS = 3;

    edit_cmd_e         cmd;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [DATA_W-1:0] edit_q, edit_d, base;
    logic              wr_pend_q, wr_pend_d;
    logic              rl_pend_q, rl_pend_d;
    logic [DATA_W-1:0] rd_data;
    logic [NIB_W-1:0]  nibs   [N_DIGITS];
    logic [SEG_W-1:0]  segs_n [N_DIGITS];

    hexed_keys #(.N_KEYS(NUM_KEYS)) i_keys (
        .clk    (clk),
        .rst_n  (rst_n),
        .key_in (key_in),
        .cmd    (cmd)
    );

    hexed_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_pend_q),
        .wr_addr     (addr_q),
        .wr_data     (edit_q),
        .rd_addr_nxt (addr_d),
        .rd_data     (rd_data)
    );

    // Next-state logic for pointer, editing register and pending flags.
    always_comb begin
        base      = rl_pend_q ? rd_data : edit_q;
        addr_d    = addr_q;
        edit_d    = base;
        wr_pend_d = 1'b0;
        rl_pend_d = 1'b0;
        unique case (cmd)
            CMD_PTR_UP: begin addr_d = addr_q + 1'b1; rl_pend_d = 1'b1; end
            CMD_PTR_DN: begin addr_d = addr_q - 1'b1; rl_pend_d = 1'b1; end
            CMD_VAL_UP: begin edit_d = base + 1'b1;   wr_pend_d = 1'b1; end
            CMD_VAL_DN: begin edit_d = base - 1'b1;   wr_pend_d = 1'b1; end
            default: ;
        endcase
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            edit_q    <= '0;
            wr_pend_q <= 1'b0;
            rl_pend_q <= 1'b0;
        end else begin
            addr_q    <= addr_d;
            edit_q    <= edit_d;
            wr_pend_q <= wr_pend_d;
            rl_pend_q <= rl_pend_d;
        end
    end

    // Digit sources: [0] low nibble, [1] high nibble, [2] pointer.
    always_comb begin
        nibs[0] = edit_q[NIB_W-1:0];
        nibs[1] = edit_q[2*NIB_W-1:NIB_W];
        nibs[2] = NIB_W'(addr_q);
    end

    for (genvar gd = 0; gd < N_DIGITS; gd++) begin : g_digit
        hexed_glyph i_glyph (.nib(nibs[gd]), .seg_n(segs_n[gd]));
    end

    assign seg_lo_n   = segs_n[0];
    assign seg_hi_n   = segs_n[1];
    assign seg_addr_n = segs_n[2];

    AST_PTR_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PTR_UP) |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1))); // R2

    AST_VAL_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_VAL_UP && !rl_pend_q) |=> (edit_q == DATA_W'($past(edit_q) + 1'b1))); // R3

    AST_RELOAD_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (rl_pend_q && cmd == CMD_NONE) |=> (edit_q == $past(rd_data))); // R7

    AST_RELOAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rl_pend_q && cmd == CMD_VAL_DN) |=> (edit_q == DATA_W'($past(rd_data) - 1'b1))); // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_NONE) |=> $stable(addr_q)); // R4

endmodule

// File: tb/test_hexmem_editor.sv
// Bench: behavioural reference model updated on every rising edge and
// compared with all three digits a quarter period later.
module test_hexmem_editor;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WD_LIMIT   = 50000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] key_in = 4'b0000;
    logic [6:0] seg_addr_n, seg_hi_n, seg_lo_n;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 0;
    string phase = "R1";

    // Reference state
    int m_mem [16];
    int m_addr, m_edit;
    bit [3:0] m_prev;
    bit m_wr, m_rl;

    always #(CLK_PERIOD/2) clk = ~clk;

    hexmem_editor i_hexmem_editor (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_in     (key_in),
        .seg_addr_n (seg_addr_n),
        .seg_hi_n   (seg_hi_n),
        .seg_lo_n   (seg_lo_n)
    );

    // R9 glyph table, active-high g..a, inverted for the pins
    function automatic logic [6:0] exp_seg(input int v);
        logic [6:0] s;
        case (v & 15)
            0: s = 7'h3F;  1: s = 7'h06;  2: s = 7'h5B;  3: s = 7'h4F;
            4: s = 7'h66;  5: s = 7'h6D;  6: s = 7'h7D;  7: s = 7'h07;
            8: s = 7'h7F;  9: s = 7'h6F; 10: s = 7'h77; 11: s = 7'h7C;
           12: s = 7'h39; 13: s = 7'h5E; 14: s = 7'h79; default: s = 7'h71;
        endcase
        return ~s;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h at cycle %0d",
                     req, what, act, exp, cycles);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Model update at each edge, then compare once outputs settle.
    always @(posedge clk) begin
        int rdata, base, n_addr, n_edit;
        bit n_wr, n_rl;
        cycles++;
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) m_mem[i] = 0;
            m_addr = 0; m_edit = 0; m_prev = 0; m_wr = 0; m_rl = 0;
        end else begin
            rdata = m_mem[m_addr];
            if (m_wr) m_mem[m_addr] = m_edit;
            base = m_rl ? rdata : m_edit;
            n_addr = m_addr; n_edit = base; n_wr = 0; n_rl = 0;
            if ($countones(key_in) == 1 && (key_in & ~m_prev) != 0) begin
                case (key_in)
                    4'b1000: begin n_addr = (m_addr + 1) & 15; n_rl = 1; end
                    4'b0100: begin n_addr = (m_addr + 15) & 15; n_rl = 1; end
                    4'b0010: begin n_edit = (base + 1) & 255; n_wr = 1; end
                    default: begin n_edit = (base + 255) & 255; n_wr = 1; end
                endcase
            end
            m_prev = key_in;
            m_addr = n_addr; m_edit = n_edit; m_wr = n_wr; m_rl = n_rl;
        end
        #(CLK_PERIOD/4);
        if (!done) begin
            check(phase, "address digit (R10)", seg_addr_n, exp_seg(m_addr));
            check(phase, "high digit (R10)",    seg_hi_n,   exp_seg(m_edit >> 4));
            check(phase, "low digit (R10)",     seg_lo_n,   exp_seg(m_edit));
        end
        if (cycles > WD_LIMIT && !done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WD_LIMIT);
            summary();
        end
    end

    // Press a key vector for 'hold' cycles, then release for one cycle.
    task automatic press(input logic [3:0] v, input int hold);
        @(negedge clk) key_in = v;
        repeat (hold - 1) @(negedge clk);
        key_in = 4'b0000;
        @(negedge clk);
    endtask

    initial begin
        logic [15:0] lfsr;
        // R1: reset state, then reset clears memory
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 and R9: walk the pointer round twice across the wrap
        phase = "R2";
        for (int i = 0; i < 17; i++) press(4'b1000, 1);
        press(4'b0100, 1);
        press(4'b0100, 1);
        phase = "R9";
        for (int i = 0; i < 16; i++) press(4'b0100, 2);

        // R3: byte steps, including wrap below 00 and above FF
        phase = "R3";
        press(4'b0010, 1);
        press(4'b0010, 1);
        for (int i = 0; i < 4; i++) press(4'b0001, 1);
        press(4'b0010, 1);
        press(4'b0010, 1);

        // R5: held keys give one step each
        phase = "R5";
        press(4'b0010, 8);
        press(4'b1000, 6);
        press(4'b0001, 5);

        // R4: chords and overlapping presses are ignored
        phase = "R4";
        press(4'b1010, 2);
        press(4'b0011, 1);
        press(4'b1111, 3);
        press(4'b1100, 1);
        @(negedge clk) key_in = 4'b1000;
        @(negedge clk) key_in = 4'b1010;
        @(negedge clk) key_in = 4'b0010;
        @(negedge clk) key_in = 4'b0000;
        @(negedge clk);

        // R6: edit a location, leave it, come back
        phase = "R6";
        for (int i = 0; i < 5; i++) press(4'b0010, 1);
        press(4'b1000, 1);
        press(4'b1000, 1);
        press(4'b0100, 1);
        press(4'b0100, 1);
        repeat (2) @(negedge clk);

        // R7: pointer step with a one-cycle stale byte
        phase = "R7";
        press(4'b0100, 1);
        press(4'b1000, 1);

        // R8: byte step in the reload cycle
        phase = "R8";
        @(negedge clk) key_in = 4'b1000;
        @(negedge clk) key_in = 4'b0010;
        @(negedge clk) key_in = 4'b0000;
        @(negedge clk) key_in = 4'b0100;
        @(negedge clk) key_in = 4'b0001;
        @(negedge clk) key_in = 4'b0000;
        repeat (2) @(negedge clk);

        // Mixed stream against the model
        phase = "R6";
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            key_in = lfsr[3:0] & {4{lfsr[7]}};
        end
        @(negedge clk) key_in = 4'b0000;

        // R1 again: mid-run reset clears pointer, byte and memory
        phase = "R1";
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        press(4'b1000, 1);
        press(4'b0100, 1);
        repeat (3) @(negedge clk);

        done = 1;
        summary();
    end

endmodule